// File: doc/BRIEF.md
# SPI Register and Fault Unit

This block is the processor-side register front end of a serial peripheral interface. It keeps the configuration byte that steers the shift engine and the pin-direction bits for the four SPI pins. It reports transfer completion, write collisions and mode faults in a status byte. The data-register path runs in two directions. A write hands a byte to the shift engine. A read returns the last byte that the engine received. The shift engine lies outside the block and connects through a busy level, a one-cycle completion strobe and a received byte.

Each status flag clears only through a two-step sequence. The first step is a status read made while the flag is set. The second step is a later access to a specific register. Between those steps the flag is "armed". If the flag is raised again before the second step, the arming is cancelled. A master that sees its select input pulled low demotes itself and releases all SPI pin drivers. The block can raise an interrupt request, which a global mask can gate.

Top module: `spi_regs`

## Requirements
- R1: After reset, the control register reads 0x04, the status register reads 0x00, the direction register reads 0x0, and irq_o is low. Register addresses are: 0 = control, 1 = status, 2 = data, 3 = pin direction.
- R2: The control byte holds these fields, from bit 7 down to bit 0: interrupt enable, system enable, open-drain, master, clock polarity, clock phase, rate[1:0]. It reads back exactly as written. In the status byte, bit 7 is the completion flag, bit 6 is the write-collision flag and bit 4 is the mode-fault flag. All other status bits read 0.
- R3: An eng_done_i pulse sets the completion flag and captures eng_rx_i. A data read returns the captured byte. The flag clears only after a status read that sees it set, followed by a read or write of the data register.
- R4: A data write made while the completion flag is set and not yet armed has no effect. tx_load_o stays low and no collision is flagged.
- R5: A data write made while eng_busy_i is high sets the write-collision flag and does not pulse tx_load_o. The flag clears after a status read that sees it set, followed by a data access.
- R6: When the master bit is 1, the synchronised select input is low and direction bit 3 (the select pin) is 0, the mode-fault flag sets. The master bit and all four direction bits are then cleared. If direction bit 3 is 1, detection is suppressed.
- R7: The mode-fault flag clears only after a status read that sees it set, followed by a control write. A control write with no prior status read leaves the flag set.
- R8: irq_o is high exactly when interrupt enable is 1, the completion flag or the mode-fault flag is set, and irq_mask_i is low.
- R9: If a flag is set again between the arming status read and the clearing access, the arming is cancelled and that access leaves the flag set.
- R10: A permitted data write, made with no blocking and no busy engine, pulses tx_load_o for one cycle in the cycle after the write, with tx_data_o equal to the written byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 2 | Register select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| eng_busy_i | input | 1 | Shift engine has a transfer in progress |
| eng_done_i | input | 1 | One-cycle transfer-complete strobe |
| eng_rx_i | input | 8 | Byte received by the shift engine |
| tx_load_o | output | 1 | Load pulse to the shift engine |
| tx_data_o | output | 8 | Byte to load into the shifter |
| ss_ni | input | 1 | Slave-select pin, active low |
| irq_mask_i | input | 1 | Global interrupt mask |
| irq_o | output | 1 | Interrupt request |
| ctrl_o | output | 8 | Current control byte |
| dir_o | output | 4 | Pin-direction bits (0 in, 1 mosi, 2 sck, 3 select) |

## Verification
The hardest case to reach is a cancelled arming. A flag must be re-raised in the short window between the arming status read and the clearing access. The stimulus pulses the completion strobe inside that window, then shows that a data access leaves the flag visible. Reaching the mode fault needs several steps. The direction and control registers are set up, select is pulled low and held through the input synchroniser, and the fault is then provoked by clearing the select direction bit. The suppressed case is exercised first.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
    localparam int DW     = 8;
    localparam int AW     = 2;
    localparam int PIN_N  = 4;
    localparam int SEL_PIN = 3;

    typedef enum logic [AW-1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_DATA = 2'd2,
        A_DIR  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       ie;
        logic       en;
        logic       odm;
        logic       mst;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = 8'h04;
endpackage

// File: rtl/spi_flag_seq.sv
module spi_flag_seq (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic stat_rd_i,
    input  logic clr_acc_i,
    output logic flag_o,
    output logic armed_o
);
    typedef struct packed {
        logic flag;
        logic armed;
    } fl_t;

    fl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.flag  = 1'b1;
            st_d.armed = 1'b0;
        end else if (st_q.armed && clr_acc_i) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end else if (stat_rd_i && st_q.flag) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flag_o  = st_q.flag;
    assign armed_o = st_q.armed;
endmodule

// File: rtl/spi_mode_fault.sv
module spi_mode_fault #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ss_ni,
    input  logic master_i,
    input  logic sel_dir_i,
    output logic ss_sync_no,
    output logic fault_o
);
    logic [SYNC_STAGES:0] sync_d, sync_q;

    generate
        if (SYNC_STAGES == 0) begin : g_nosync
            always_comb begin
                sync_d = sync_q;
                sync_d[0] = ss_ni;
            end
            assign ss_sync_no = ss_ni;
        end else begin : g_sync
            always_comb begin
                sync_d = {sync_q[SYNC_STAGES-1:0], ss_ni};
            end
            assign ss_sync_no = sync_q[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= sync_d;
    end

    assign fault_o = master_i && !ss_sync_no && !sel_dir_i;
endmodule

// File: rtl/spi_regs.sv
module spi_regs
    import spi_regs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [AW-1:0] addr_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    input  logic          eng_busy_i,
    input  logic          eng_done_i,
    input  logic [DW-1:0] eng_rx_i,
    output logic          tx_load_o,
    output logic [DW-1:0] tx_data_o,
    input  logic          ss_ni,
    input  logic          irq_mask_i,
    output logic          irq_o,
    output logic [DW-1:0] ctrl_o,
    output logic [PIN_N-1:0] dir_o
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [PIN_N-1:0] dir;
        logic [DW-1:0]    rxbuf;
        logic             load;
        logic [DW-1:0]    txd;
    } regs_t;

    regs_t r_d, r_q;

    logic stat_rd, data_acc, data_wr, ctrl_wr, dir_wr;
    logic spif, spif_armed, wcol, wcol_armed, modf, modf_armed;
    logic blocked, wcol_set, load_ok, fault_w, ss_sync_n;

    assign stat_rd  = rd_i && (addr_i == A_STAT);
    assign data_acc = (rd_i || wr_i) && (addr_i == A_DATA);
    assign data_wr  = wr_i && (addr_i == A_DATA);
    assign ctrl_wr  = wr_i && (addr_i == A_CTRL);
    assign dir_wr   = wr_i && (addr_i == A_DIR);

    assign blocked  = spif && !spif_armed;
    assign wcol_set = data_wr && !blocked && eng_busy_i;
    assign load_ok  = data_wr && !blocked && !eng_busy_i;

    spi_mode_fault #(.SYNC_STAGES(SYNC_STAGES)) u_fault (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ss_ni      (ss_ni),
        .master_i   (r_q.ctrl.mst),
        .sel_dir_i  (r_q.dir[SEL_PIN]),
        .ss_sync_no (ss_sync_n),
        .fault_o    (fault_w)
    );

    spi_flag_seq u_spif (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(eng_done_i), .stat_rd_i(stat_rd),
        .clr_acc_i(data_acc), .flag_o(spif), .armed_o(spif_armed)
    );

    spi_flag_seq u_wcol (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(wcol_set), .stat_rd_i(stat_rd),
        .clr_acc_i(data_acc), .flag_o(wcol), .armed_o(wcol_armed)
    );

    spi_flag_seq u_modf (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(fault_w), .stat_rd_i(stat_rd),
        .clr_acc_i(ctrl_wr), .flag_o(modf), .armed_o(modf_armed)
    );

    always_comb begin
        r_d      = r_q;
        r_d.load = load_ok;
        if (load_ok)    r_d.txd   = wdata_i;
        if (ctrl_wr)    r_d.ctrl  = ctrl_t'(wdata_i);
        if (dir_wr)     r_d.dir   = wdata_i[PIN_N-1:0];
        if (eng_done_i) r_d.rxbuf = eng_rx_i;
        if (fault_w) begin
            r_d.ctrl.mst = 1'b0;
            r_d.dir      = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q      <= '0;
            r_q.ctrl <= CTRL_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (addr_i)
            A_CTRL:  rdata_o = r_q.ctrl;
            A_STAT:  rdata_o = {spif, wcol, 1'b0, modf, 4'b0000};
            A_DATA:  rdata_o = r_q.rxbuf;
            default: rdata_o = {{(DW-PIN_N){1'b0}}, r_q.dir};
        endcase
    end

    assign tx_load_o = r_q.load;
    assign tx_data_o = r_q.txd;
    assign ctrl_o    = r_q.ctrl;
    assign dir_o     = r_q.dir;
    assign irq_o     = r_q.ctrl.ie && (spif || modf) && !irq_mask_i;
endmodule

// File: rtl/spi_regs_chk.sv
module spi_regs_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       fault,
    input logic [7:0] ctrl,
    input logic [3:0] dir,
    input logic       modf,
    input logic       rd,
    input logic [1:0] addr,
    input logic [7:0] rdata,
    input logic       busy,
    input logic       tx_load,
    input logic       irq
);
    // R6: a detected fault demotes the master and frees the pins
    a_r6_fault_demotes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault |=> (!ctrl[4] && dir == 4'h0 && modf));

    // R2: unused status bits read zero
    a_r2_stat_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd && addr == 2'd1) |-> ((rdata & 8'h2F) == 8'h00));

    // R5: no load follows a write made during a busy engine
    a_r5_no_load_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_load |-> $past(!busy));

    // R8: no request without interrupt enable
    a_r8_irq_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl[7] |-> !irq);
endmodule

bind spi_regs spi_regs_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fault   (fault_w),
    .ctrl    (ctrl_o),
    .dir     (dir_o),
    .modf    (modf),
    .rd      (rd_i),
    .addr    (addr_i),
    .rdata   (rdata_o),
    .busy    (eng_busy_i),
    .tx_load (tx_load_o),
    .irq     (irq_o)
);

// File: tb/test_spi_regs.sv
module test_spi_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       rd = 1'b0, wr = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic       busy = 1'b0, done = 1'b0;
    logic [7:0] rx = '0;
    logic       tx_load;
    logic [7:0] tx_data;
    logic       ss_n = 1'b1, mask = 1'b0, irq;
    logic [7:0] ctrl;
    logic [3:0] dir;

    always #2 clk = ~clk;

    spi_regs i_spi_regs (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
        .wdata_i(wdata), .rdata_o(rdata), .eng_busy_i(busy), .eng_done_i(done),
        .eng_rx_i(rx), .tx_load_o(tx_load), .tx_data_o(tx_data), .ss_ni(ss_n),
        .irq_mask_i(mask), .irq_o(irq), .ctrl_o(ctrl), .dir_o(dir)
    );

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    function automatic logic [7:0] actual(int sel);
        case (sel)
            0: return rdata;
            1: return {7'd0, tx_load};
            2: return tx_data;
            3: return {7'd0, irq};
            4: return ctrl;
            default: return {4'd0, dir};
        endcase
    endfunction

    // monitor: pops every expectation posted for this cycle
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] a;
            it = q.pop_front();
            a = actual(it.sel);
            n_chk++;
            if (a !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", it.tag, a, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        step();
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [7:0] e, input string tag);
        addr = a; rd = 1'b1;
        q.push_back('{0, e, tag});
        step();
        rd = 1'b0;
    endtask

    task automatic expect_sig(input int sel, input logic [7:0] e, input string tag);
        q.push_back('{sel, e, tag});
        @(negedge clk);
        step();
    endtask

    task automatic pulse_done(input logic [7:0] b);
        rx = b; done = 1'b1;
        step();
        done = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset values
        bus_rd(2'd0, 8'h04, "R1 ctrl");
        bus_rd(2'd1, 8'h00, "R1 status");
        bus_rd(2'd3, 8'h00, "R1 dir");
        expect_sig(3, 8'h00, "R1 irq");
        // R2 control readback
        bus_wr(2'd0, 8'hAB);
        bus_rd(2'd0, 8'hAB, "R2 ctrl readback");
        expect_sig(4, 8'hAB, "R2 ctrl_o");
        bus_wr(2'd0, 8'h04);
        // R10 plain write
        bus_wr(2'd2, 8'h5A);
        q.push_back('{1, 8'h01, "R10 load pulse"});
        q.push_back('{2, 8'h5A, "R10 load data"});
        @(negedge clk); step();
        expect_sig(1, 8'h00, "R10 pulse ends");
        // R3 completion and clear
        pulse_done(8'hC3);
        bus_rd(2'd1, 8'h80, "R3 flag set");
        bus_rd(2'd2, 8'hC3, "R3 rx byte");
        bus_rd(2'd1, 8'h00, "R3 cleared");
        // R4 blocked write
        pulse_done(8'h11);
        bus_wr(2'd2, 8'h77);
        expect_sig(1, 8'h00, "R4 no load");
        bus_rd(2'd1, 8'h80, "R4 no collision");
        bus_wr(2'd2, 8'h66);
        q.push_back('{1, 8'h01, "R10 armed write loads"});
        q.push_back('{2, 8'h66, "R10 armed write data"});
        @(negedge clk); step();
        bus_rd(2'd1, 8'h00, "R3 cleared by write");
        // R5 collision
        busy = 1'b1;
        bus_wr(2'd2, 8'h99);
        expect_sig(1, 8'h00, "R5 no load busy");
        bus_rd(2'd1, 8'h40, "R5 wcol set");
        bus_rd(2'd2, 8'h11, "R5 data access");
        bus_rd(2'd1, 8'h00, "R5 wcol cleared");
        busy = 1'b0;
        // R9 cancelled arming
        pulse_done(8'h22);
        bus_rd(2'd1, 8'h80, "R9 arm");
        pulse_done(8'h33);
        bus_rd(2'd2, 8'h33, "R9 data");
        bus_rd(2'd1, 8'h80, "R9 flag kept");
        bus_rd(2'd2, 8'h33, "R9 data again");
        bus_rd(2'd1, 8'h00, "R9 now cleared");
        // R8 interrupt
        bus_wr(2'd0, 8'h84);
        pulse_done(8'h44);
        expect_sig(3, 8'h01, "R8 irq on");
        mask = 1'b1;
        expect_sig(3, 8'h00, "R8 masked");
        mask = 1'b0;
        bus_rd(2'd1, 8'h80, "R8 status");
        bus_rd(2'd2, 8'h44, "R8 data");
        expect_sig(3, 8'h00, "R8 irq off");
        // R6 suppressed, then fault
        bus_wr(2'd3, 8'h0F);
        bus_wr(2'd0, 8'h54);
        ss_n = 1'b0;
        repeat (5) step();
        bus_rd(2'd1, 8'h00, "R6 suppressed");
        bus_rd(2'd0, 8'h54, "R6 master kept");
        bus_wr(2'd3, 8'h07);
        step(); step();
        ss_n = 1'b1;
        expect_sig(4, 8'h44, "R6 master cleared");
        bus_rd(2'd3, 8'h00, "R6 dir cleared");
        // R7 clear sequence
        bus_wr(2'd0, 8'h04);
        bus_rd(2'd1, 8'h10, "R7 not cleared unarmed");
        bus_rd(2'd2, 8'h44, "R7 data access");
        bus_rd(2'd1, 8'h10, "R7 data access no clear");
        bus_wr(2'd0, 8'h04);
        bus_rd(2'd1, 8'h00, "R7 cleared");
        step();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule